// File: doc/BRIEF.md
# Inter-Processor Interrupt Command Register

This block is the sending side of an inter-processor interrupt. Software sees two 32-bit words on a simple register port: a high word that holds an explicit destination processor ID, and a low word that holds the vector, delivery mode, level flag and a two-bit destination shorthand. Software fills the high word first. A write to the low word then launches one outbound message on a valid/ready interface.

The shorthand takes precedence over the explicit ID. It can target the sender itself, every processor, or every processor except the sender. The message also carries a broadcast flag and an exclude-self flag, so the fabric on the receiving side can act on it without decoding the shorthand again. The sender's own ID is an input and is captured when the message launches.

A pending bit in the low word reads as one from launch until the cycle in which the message is accepted. Software polls this bit before it sends again. While the bit is set, writes to the low word are dropped.

Top module: `ipi_cmd_reg`

## Requirements
- R1: After reset, msg_valid is 0 and both the low word (offset 0x300) and the high word (offset 0x310) read as 0.
- R2: A write to the high word stores wdata[31:24] as the explicit destination ID. It reads back in bits 31:24 of that word, with every other bit reading 0.
- R3: A write to the low word while idle captures the vector from bits 7:0, the delivery mode from bits 10:8, the level flag from bit 14 and the shorthand from bits 19:18. These fields read back in the same positions, and every other bit reads 0 except bit 12.
- R4: The cycle after a low-word write while idle, msg_valid is 1 and bit 12 of the low word (pending) reads 1.
- R5: While msg_valid is 1 and msg_ready is 0, msg_valid stays 1 and every message field holds its value. After a cycle in which msg_valid and msg_ready are both 1, msg_valid and the pending bit read 0.
- R6: Shorthand 0 sends to the high-word ID. msg_bcast is 1 only when that ID is 0xFF, and msg_excl_self is 0.
- R7: Shorthand 1 sends to own_id as sampled at the launching write, with msg_bcast and msg_excl_self both 0.
- R8: Shorthand 2 sends with msg_dest 0xFF, msg_bcast 1 and msg_excl_self 0.
- R9: Shorthand 3 sends with msg_dest 0xFF, msg_bcast 1 and msg_excl_self 1.
- R10: A low-word write while pending is ignored. The message in flight and the low-word readback do not change.
- R11: A write to any offset other than the two command words changes neither word, and a read of such an offset returns 0.
- R12: Writing the high word while a message is pending does not change msg_dest of that message.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| own_id | input | 8 | ID of this processor |
| msg_valid | output | 1 | Outbound message valid |
| msg_ready | input | 1 | Outbound message accepted |
| msg_vector | output | 8 | Interrupt vector |
| msg_mode | output | 3 | Delivery mode |
| msg_level | output | 1 | Level-assert flag |
| msg_dest | output | 8 | Resolved destination ID |
| msg_bcast | output | 1 | Message goes to all processors |
| msg_excl_self | output | 1 | Receivers with own_id skip the message |

## Verification
Several rules are checked by assertions on every cycle: the handshake holds valid and the message fields steady until acceptance, acceptance clears valid, a write while idle always launches, the pending readback tracks valid, and the exclude-self and broadcast flags are consistent with the destination. Only the bench scenarios can show the mapping of each shorthand to a destination for specific IDs, that a dropped write leaves the exact earlier fields in place, and that a late high-word write or a write to a stray offset has no visible effect.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
    localparam int ID_W   = 8;
    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        SH_EXPLICIT = 2'd0,
        SH_SELF     = 2'd1,
        SH_ALL      = 2'd2,
        SH_OTHERS   = 2'd3
    } shorthand_e;

    typedef struct packed {
        logic [7:0] vector;
        logic [2:0] mode;
        logic       level;
        shorthand_e shorthand;
    } ipi_cmd_t;

    typedef struct packed {
        ipi_cmd_t        cmd;
        logic [ID_W-1:0] dest;
        logic            bcast;
        logic            excl_self;
    } ipi_msg_t;

    typedef struct packed {
        ipi_msg_t        msg;
        logic            pending;
        logic [ID_W-1:0] hi_id;
    } ipi_state_t;
endpackage

// File: rtl/ipi_lo_decode.sv
module ipi_lo_decode
    import ipi_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output ipi_cmd_t          cmd
);
    logic unused_lo_bits;

    always_comb begin
        cmd.vector    = word[7:0];
        cmd.mode      = word[10:8];
        cmd.level     = word[14];
        cmd.shorthand = shorthand_e'(word[19:18]);
    end

    assign unused_lo_bits = ^{word[31:20], word[17:15], word[13:11]};
endmodule

// File: rtl/ipi_dest_resolve.sv
module ipi_dest_resolve
    import ipi_pkg::*;
(
    input  shorthand_e      sh,
    input  logic [ID_W-1:0] explicit_id,
    input  logic [ID_W-1:0] own_id,
    output logic [ID_W-1:0] dest,
    output logic            bcast,
    output logic            excl_self
);
    localparam logic [ID_W-1:0] ALL_ID = '1;

    always_comb begin
        dest      = explicit_id;
        bcast     = (explicit_id == ALL_ID);
        excl_self = 1'b0;
        case (sh)
            SH_SELF: begin
                dest  = own_id;
                bcast = 1'b0;
            end
            SH_ALL: begin
                dest  = ALL_ID;
                bcast = 1'b1;
            end
            SH_OTHERS: begin
                dest      = ALL_ID;
                bcast     = 1'b1;
                excl_self = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/ipi_cmd_reg.sv
module ipi_cmd_reg
    import ipi_pkg::*;
#(
    parameter int              ADDR_W = 12,
    parameter logic [ADDR_W-1:0] LO_OFS = 12'h300,
    parameter logic [ADDR_W-1:0] HI_OFS = 12'h310
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [7:0]        own_id,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic [7:0]        msg_vector,
    output logic [2:0]        msg_mode,
    output logic              msg_level,
    output logic [7:0]        msg_dest,
    output logic              msg_bcast,
    output logic              msg_excl_self
);
    localparam int LOW_ID_BITS = WORD_W - ID_W;

    ipi_state_t st_d, st_q;
    ipi_cmd_t   wr_cmd;
    logic [ID_W-1:0] res_dest;
    logic       res_bcast, res_excl;
    logic       lo_hit, hi_hit;

    ipi_lo_decode u_dec (
        .word (reg_wdata),
        .cmd  (wr_cmd)
    );

    ipi_dest_resolve u_res (
        .sh          (wr_cmd.shorthand),
        .explicit_id (st_q.hi_id),
        .own_id      (own_id),
        .dest        (res_dest),
        .bcast       (res_bcast),
        .excl_self   (res_excl)
    );

    always_comb begin
        lo_hit = reg_we && (reg_addr == LO_OFS);
        hi_hit = reg_we && (reg_addr == HI_OFS);
        st_d   = st_q;
        if (hi_hit) st_d.hi_id = reg_wdata[WORD_W-1:LOW_ID_BITS];
        if (st_q.pending && msg_ready) st_d.pending = 1'b0;
        if (lo_hit && !st_q.pending) begin
            st_d.msg.cmd       = wr_cmd;
            st_d.msg.dest      = res_dest;
            st_d.msg.bcast     = res_bcast;
            st_d.msg.excl_self = res_excl;
            st_d.pending       = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == LO_OFS)
            reg_rdata = {12'b0, st_q.msg.cmd.shorthand, 3'b0, st_q.msg.cmd.level,
                         1'b0, st_q.pending, 1'b0, st_q.msg.cmd.mode, st_q.msg.cmd.vector};
        else if (reg_addr == HI_OFS)
            reg_rdata = {st_q.hi_id, {LOW_ID_BITS{1'b0}}};
    end

    assign msg_valid     = st_q.pending;
    assign msg_vector    = st_q.msg.cmd.vector;
    assign msg_mode      = st_q.msg.cmd.mode;
    assign msg_level     = st_q.msg.cmd.level;
    assign msg_dest      = st_q.msg.dest;
    assign msg_bcast     = st_q.msg.bcast;
    assign msg_excl_self = st_q.msg.excl_self;
endmodule

// File: rtl/ipi_cmd_reg_chk.sv
module ipi_cmd_reg_chk #(
    parameter int              ADDR_W = 12,
    parameter logic [ADDR_W-1:0] LO_OFS = 12'h300
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [31:0]       reg_rdata,
    input logic              msg_valid,
    input logic              msg_ready,
    input logic [7:0]        msg_vector,
    input logic [2:0]        msg_mode,
    input logic              msg_level,
    input logic [7:0]        msg_dest,
    input logic              msg_bcast,
    input logic              msg_excl_self
);
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_vector) && $stable(msg_mode)
            && $stable(msg_level) && $stable(msg_dest) && $stable(msg_bcast)
            && $stable(msg_excl_self)));

    assert_accept_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_ready) |=> !msg_valid);

    assert_launch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!msg_valid && reg_we && reg_addr == LO_OFS) |=> msg_valid);

    assert_pending_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == LO_OFS) |-> (reg_rdata[12] == msg_valid));

    assert_excl_bcast_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_excl_self) |-> msg_bcast);

    assert_bcast_dest_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_bcast) |-> (msg_dest == 8'hFF));
endmodule

bind ipi_cmd_reg ipi_cmd_reg_chk #(.ADDR_W(ADDR_W), .LO_OFS(LO_OFS)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_rdata(reg_rdata), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_vector(msg_vector), .msg_mode(msg_mode), .msg_level(msg_level),
    .msg_dest(msg_dest), .msg_bcast(msg_bcast), .msg_excl_self(msg_excl_self)
);

// File: tb/sim_ipi_cmd_reg.sv
`timescale 1ns/1ps
module sim_ipi_cmd_reg;
    localparam logic [11:0] LO = 12'h300;
    localparam logic [11:0] HI = 12'h310;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  own_id = '0;
    logic        msg_valid, msg_ready = 1'b0;
    logic [7:0]  msg_vector, msg_dest;
    logic [2:0]  msg_mode;
    logic        msg_level, msg_bcast, msg_excl_self;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    ipi_cmd_reg u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .own_id(own_id),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vector(msg_vector),
        .msg_mode(msg_mode), .msg_level(msg_level), .msg_dest(msg_dest),
        .msg_bcast(msg_bcast), .msg_excl_self(msg_excl_self)
    );

    typedef struct packed {
        logic [7:0]  hi;
        logic [31:0] lo;
        logic [7:0]  own;
        logic [7:0]  dest;
        logic        bc;
        logic        xs;
    } vec_t;

    localparam vec_t TBL [5] = '{
        '{8'h05, 32'h0000_4041, 8'h02, 8'h05, 1'b0, 1'b0},
        '{8'hFF, 32'h0000_0522, 8'h02, 8'hFF, 1'b1, 1'b0},
        '{8'h07, 32'h0004_4430, 8'h09, 8'h09, 1'b0, 1'b0},
        '{8'h07, 32'h0008_40F0, 8'h09, 8'hFF, 1'b1, 1'b0},
        '{8'h11, 32'h000C_42EE, 8'h03, 8'hFF, 1'b1, 1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic accept();
        msg_ready = 1'b1;
        @(negedge clk);
        msg_ready = 1'b0;
    endtask

    function automatic logic [31:0] lo_view(input logic [31:0] w, input logic pend);
        return {12'b0, w[19:18], 3'b0, w[14], 1'b0, pend, 1'b0, w[10:8], w[7:0]};
    endfunction

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 valid", {31'b0, msg_valid}, 32'd0);
        rd(LO, r); check("R1 low", r, 32'd0);
        rd(HI, r); check("R1 high", r, 32'd0);

        // R2 high word readback
        wr(HI, 32'hA5FF_FFFF);
        rd(HI, r); check("R2 high readback", r, 32'hA500_0000);

        // Table walk: R3 R4 R5 R6 R7 R8 R9
        foreach (TBL[i]) begin
            own_id = TBL[i].own;
            wr(HI, {TBL[i].hi, 24'h0});
            wr(LO, TBL[i].lo);
            own_id = 8'h77;
            check("R4 valid", {31'b0, msg_valid}, 32'd1);
            rd(LO, r); check("R3 R4 low readback", r, lo_view(TBL[i].lo, 1'b1));
            check("R3 vector", {24'b0, msg_vector}, {24'b0, TBL[i].lo[7:0]});
            check("R3 mode", {29'b0, msg_mode}, {29'b0, TBL[i].lo[10:8]});
            check("R3 level", {31'b0, msg_level}, {31'b0, TBL[i].lo[14]});
            check("R6 R7 R8 R9 dest", {24'b0, msg_dest}, {24'b0, TBL[i].dest});
            check("R6 R8 R9 bcast", {31'b0, msg_bcast}, {31'b0, TBL[i].bc});
            check("R9 excl_self", {31'b0, msg_excl_self}, {31'b0, TBL[i].xs});
            accept();
            check("R5 cleared", {31'b0, msg_valid}, 32'd0);
            rd(LO, r); check("R5 pending bit", {31'b0, r[12]}, 32'd0);
        end

        // R5 hold without ready; R10 ignored low write; R12 late high write
        own_id = 8'h02;
        wr(HI, 32'h2300_0000);
        wr(LO, 32'h0000_4112);
        repeat (3) @(negedge clk);
        check("R5 held valid", {31'b0, msg_valid}, 32'd1);
        check("R5 held vector", {24'b0, msg_vector}, 32'h12);
        wr(LO, 32'h000C_0699);
        check("R10 vector", {24'b0, msg_vector}, 32'h12);
        check("R10 mode", {29'b0, msg_mode}, 32'd1);
        check("R10 excl", {31'b0, msg_excl_self}, 32'd0);
        rd(LO, r); check("R10 low readback", r, lo_view(32'h0000_4112, 1'b1));
        wr(HI, 32'h4400_0000);
        check("R12 dest", {24'b0, msg_dest}, 32'h23);
        accept();
        check("R5 accept", {31'b0, msg_valid}, 32'd0);

        // R11 stray offsets
        wr(12'h200, 32'hFFFF_FFFF);
        wr(12'h30C, 32'hFFFF_FFFF);
        check("R11 no launch", {31'b0, msg_valid}, 32'd0);
        rd(HI, r); check("R11 high kept", r, 32'h4400_0000);
        rd(LO, r); check("R11 low kept", r, lo_view(32'h0000_4112, 1'b0));
        rd(12'h200, r); check("R11 unmapped read", r, 32'd0);

        finished = 1'b1;
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule